// File: doc/BRIEF.md
# Display Row Scanner with Segment and Common Drive Encoding

This block sequences the row scan of a passive dot-matrix liquid crystal panel and decides, for every segment and common output, which drive voltage it should carry on the current line. A scan frame consists of a programmable number of scrolled lines followed by one icon line. At the start of each frame, a start-line register is copied into a row counter. The counter then advances on every line strobe, so the panel can be scrolled without touching the pixel memory.

On each line strobe the block latches the 128-bit row that the pixel memory returns for the address it presents. From that latched row, the mode inputs and a frame-alternating polarity flag, it produces a symbolic drive-level code per output. The mode inputs are display enable, inversion, force-all-lit and column mirroring. The memory array, the analog level generation and the bias choice sit outside this block.

Top module: `lcd_scan_drive`

## Requirements
- R1: After reset the row address is 0 and every segment and common output is VSS (code 0) until the first line strobe is taken.
- R2: The start line is written with startLineWe and is used only when a new frame begins. The first scrolled line of every frame addresses the start line, and a start value of 80 or more loads as 0.
- R3: Each line strobe on a scrolled line advances the row address by one, wrapping from 79 to 0. A frame has dutyIn scrolled lines, where 0 counts as 1 and values above 80 count as 80.
- R4: After the scrolled lines of a frame, the next line is the icon line. It addresses row 80 whatever the start line is, selects common output 80, and its strobe begins the next frame.
- R5: The polarity flag starts at 0 and toggles at every frame start. A common output is VSS when selected and V1 when not selected under polarity 1, and V0 when selected and V4 when not selected under polarity 0. Scrolled line k (counted from 0 in the frame) selects common output k.
- R6: Drive codes are VSS=0, V0=1, V1=2, V2=3, V3=4, V4=5. A segment shows V0 for a lit pixel and V2 for an unlit pixel under polarity 1, and VSS for lit and V3 for unlit under polarity 0. A row bit of 1 means lit.
- R7: With reverseOn set, lit and unlit are exchanged for every segment.
- R8: With allOn set, every segment takes the lit level, and this overrides reverseOn.
- R9: With dispOn clear, every segment and common output is VSS, and this overrides all other modes.
- R10: With mirrorOn clear, segment s shows row bit s. With mirrorOn set, segment s shows row bit 127-s.
- R11: Mode inputs take effect on the outputs immediately and leave the latched row unchanged. Clearing them restores the data-driven levels without a new line strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lineTick | input | 1 | One-cycle line strobe |
| startLineWe | input | 1 | Write enable for the start-line register |
| startLineIn | input | 7 | New start line |
| dutyIn | input | 7 | Scrolled lines per frame |
| dispOn | input | 1 | Display enable |
| reverseOn | input | 1 | Invert lit/unlit |
| allOn | input | 1 | Force all segments lit |
| mirrorOn | input | 1 | Reverse column-to-segment mapping |
| ramAddr | output | 7 | Row address presented to pixel memory |
| ramData | input | 128 | Row read from pixel memory (combinational return) |
| segLevel | output | 384 | Three-bit drive code per segment, segment s at bits 3s+2..3s |
| comLevel | output | 243 | Three-bit drive code per common, common c at bits 3c+2..3c |

## Verification
A wrong row counter or a wrong start-line load shows up on ramAddr in the same cycle. Because that row is latched at the next strobe, the mistake also reaches segLevel one strobe later. A polarity flag that drifts flips every common code at the next frame's first strobe. A wrong scan index moves the selected common code to the wrong output on the next strobe. Mode errors are combinational and appear on the segment codes in the cycle the mode input changes. Comparing ramAddr, segLevel and comLevel with a behavioural model on every cycle therefore localises each fault to within one line.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int IDX_W = 7;

  typedef enum logic [2:0] {
    LVL_VSS = 3'd0,
    LVL_V0  = 3'd1,
    LVL_V1  = 3'd2,
    LVL_V2  = 3'd3,
    LVL_V3  = 3'd4,
    LVL_V4  = 3'd5
  } drvLevel_t;

  typedef struct packed {
    logic             latchEn;
    logic             iconLine;
    logic             mPhase;
    logic [IDX_W-1:0] scanIdx;
  } scanStrobe_t;
endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_ROWS = 80,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lineTick,
  input  logic              startLineWe,
  input  logic [ADDR_W-1:0] startLineIn,
  input  logic [ADDR_W-1:0] dutyIn,
  output logic [ADDR_W-1:0] ramAddr,
  output scanStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] ICON_ROW = ADDR_W'(NUM_ROWS);
  localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(NUM_ROWS - 1);

  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] lineCnt;
  logic [IDX_W-1:0]  scanIdx;
  logic              mFlag;
  logic [ADDR_W-1:0] effDuty;
  logic [ADDR_W-1:0] loadLine;
  logic              iconPhase;

  always_comb begin
    if (dutyIn == '0)
      effDuty = ADDR_W'(1);
    else if (dutyIn > ICON_ROW)
      effDuty = ICON_ROW;
    else
      effDuty = dutyIn;
  end

  assign iconPhase = (IDX_W'(scanIdx) >= IDX_W'(effDuty));
  assign loadLine  = (startReg >= ICON_ROW) ? '0 : startReg;
  assign ramAddr   = iconPhase ? ICON_ROW : lineCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startReg <= '0;
      lineCnt  <= '0;
      scanIdx  <= '0;
      mFlag    <= 1'b0;
    end else begin
      if (lineTick) begin
        if (iconPhase) begin
          scanIdx <= '0;
          lineCnt <= loadLine;
          mFlag   <= ~mFlag;
        end else begin
          scanIdx <= scanIdx + IDX_W'(1);
          lineCnt <= (lineCnt >= LAST_ROW) ? '0 : lineCnt + ADDR_W'(1);
        end
      end
      if (startLineWe)
        startReg <= startLineIn;
    end
  end

  assign strobe.latchEn  = lineTick;
  assign strobe.iconLine = iconPhase;
  assign strobe.mPhase   = mFlag;
  assign strobe.scanIdx  = scanIdx;

  AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && iconPhase) |=> (lineCnt == (($past(startReg) >= ICON_ROW) ? '0 : $past(startReg)))); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && !iconPhase) |=> (scanIdx == IDX_W'($past(scanIdx) + IDX_W'(1)))); // R3

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ramAddr <= ICON_ROW)); // R3

  AST_M_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (lineTick && iconPhase) |=> (mFlag != $past(mFlag))); // R5

  AST_M_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(lineTick && iconPhase) |=> $stable(mFlag)); // R5
endmodule

// File: rtl/lcd_drive_dp.sv
module lcd_drive_dp
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 128,
  parameter int NUM_COM = 81
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scanStrobe_t          strobe,
  input  logic [NUM_SEG-1:0]   ramData,
  input  logic                 dispOn,
  input  logic                 reverseOn,
  input  logic                 allOn,
  input  logic                 mirrorOn,
  output logic [NUM_SEG*3-1:0] segLevel,
  output logic [NUM_COM*3-1:0] comLevel
);
  localparam int ICON_COM = NUM_COM - 1;

  logic [NUM_SEG-1:0] rowLatch;
  logic [IDX_W-1:0]   selLine;
  logic               iconLat;
  logic               mLat;
  logic               validLat;
  logic               outActive;
  logic [NUM_COM-1:0] comSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowLatch <= '0;
      selLine  <= '0;
      iconLat  <= 1'b0;
      mLat     <= 1'b0;
      validLat <= 1'b0;
    end else if (strobe.latchEn) begin
      rowLatch <= ramData;
      selLine  <= strobe.scanIdx;
      iconLat  <= strobe.iconLine;
      mLat     <= strobe.mPhase;
      validLat <= 1'b1;
    end
  end

  assign outActive = dispOn && validLat;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic      pixBit;
    logic      lit;
    drvLevel_t lvl;
    assign pixBit = mirrorOn ? rowLatch[NUM_SEG-1-s] : rowLatch[s];
    assign lit    = allOn | (pixBit ^ reverseOn);
    always_comb begin
      if (!outActive)
        lvl = LVL_VSS;
      else if (mLat)
        lvl = lit ? LVL_V0 : LVL_V2;
      else
        lvl = lit ? LVL_VSS : LVL_V3;
    end
    assign segLevel[s*3 +: 3] = lvl;
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    drvLevel_t lvl;
    if (c == ICON_COM) begin : g_icon
      assign comSel[c] = validLat && iconLat;
    end else begin : g_line
      assign comSel[c] = validLat && !iconLat && (selLine == IDX_W'(c));
    end
    always_comb begin
      if (!outActive)
        lvl = LVL_VSS;
      else if (mLat)
        lvl = comSel[c] ? LVL_VSS : LVL_V1;
      else
        lvl = comSel[c] ? LVL_V0 : LVL_V4;
    end
    assign comLevel[c*3 +: 3] = lvl;
  end

  AST_OFF_VSS: assert property (@(posedge clk) disable iff (!rst_n)
    !dispOn |-> (segLevel == '0 && comLevel == '0)); // R9

  AST_ONE_COM: assert property (@(posedge clk) disable iff (!rst_n)
    validLat |-> ($countones(comSel) == 1)); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchEn |=> $stable(rowLatch)); // R11
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG  = 128,
  parameter int NUM_ROWS = 80,
  parameter int ADDR_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lineTick,
  input  logic                    startLineWe,
  input  logic [ADDR_W-1:0]       startLineIn,
  input  logic [ADDR_W-1:0]       dutyIn,
  input  logic                    dispOn,
  input  logic                    reverseOn,
  input  logic                    allOn,
  input  logic                    mirrorOn,
  output logic [ADDR_W-1:0]       ramAddr,
  input  logic [NUM_SEG-1:0]      ramData,
  output logic [NUM_SEG*3-1:0]    segLevel,
  output logic [(NUM_ROWS+1)*3-1:0] comLevel
);
  localparam int NUM_COM = NUM_ROWS + 1;

  scanStrobe_t strobe;

  lcd_scan_ctrl #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lineTick(lineTick),
    .startLineWe(startLineWe), .startLineIn(startLineIn), .dutyIn(dutyIn),
    .ramAddr(ramAddr), .strobe(strobe)
  );

  lcd_drive_dp #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ramData(ramData),
    .dispOn(dispOn), .reverseOn(reverseOn), .allOn(allOn), .mirrorOn(mirrorOn),
    .segLevel(segLevel), .comLevel(comLevel)
  );
endmodule

// File: tb/lcd_scan_drive_tb.sv
`timescale 1ns/100ps
module lcd_scan_drive_tb;
  localparam int NSEG = 128;
  localparam int NROW = 80;
  localparam int NCOM = 81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lineTick = 1'b0, startLineWe = 1'b0;
  logic [6:0] startLineIn = '0, dutyIn = 7'd8;
  logic dispOn = 1'b0, reverseOn = 1'b0, allOn = 1'b0, mirrorOn = 1'b0;
  logic [6:0] ramAddr;
  logic [NSEG-1:0] ramData;
  logic [NSEG*3-1:0] segLevel;
  logic [NCOM*3-1:0] comLevel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  logic [NSEG-1:0] mem [0:NROW];
  initial begin
    for (int r = 0; r <= NROW; r++)
      for (int c = 0; c < NSEG; c++)
        mem[r][c] = (r == NROW) ? ((c % 9) == 0) : (((r*5 + c*3 + (c >> 4)) % 7) < 3);
  end
  assign ramData = (ramAddr <= 7'(NROW)) ? mem[ramAddr] : '0;

  lcd_scan_drive u_dut (
    .clk(clk), .rst_n(rst_n), .lineTick(lineTick), .startLineWe(startLineWe),
    .startLineIn(startLineIn), .dutyIn(dutyIn), .dispOn(dispOn),
    .reverseOn(reverseOn), .allOn(allOn), .mirrorOn(mirrorOn),
    .ramAddr(ramAddr), .ramData(ramData), .segLevel(segLevel), .comLevel(comLevel)
  );

  // behavioural reference
  int mStart, mLine, mScan, mSel;
  bit mM, mIcon, mValid, mLm;
  logic [NSEG-1:0] mRow;

  function automatic int effDuty(int d);
    if (d == 0) return 1;
    if (d > NROW) return NROW;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mStart = 0; mLine = 0; mScan = 0; mM = 0;
      mSel = 0; mIcon = 0; mValid = 0; mLm = 0; mRow = '0;
    end else begin
      bit icon;
      icon = (mScan >= effDuty(int'(dutyIn)));
      if (lineTick) begin
        mRow = mem[icon ? NROW : mLine];
        mSel = mScan; mIcon = icon; mLm = mM; mValid = 1;
        if (icon) begin
          mScan = 0;
          mLine = (mStart >= NROW) ? 0 : mStart;
          mM = ~mM;
        end else begin
          mScan = mScan + 1;
          mLine = (mLine >= NROW - 1) ? 0 : mLine + 1;
        end
      end
      if (startLineWe) mStart = int'(startLineIn);
    end
  end

  function automatic logic [NSEG*3-1:0] expSeg();
    logic [NSEG*3-1:0] v;
    for (int s = 0; s < NSEG; s++) begin
      bit b, lit;
      int code;
      b = mirrorOn ? mRow[NSEG-1-s] : mRow[s];
      lit = allOn ? 1'b1 : (b ^ reverseOn);
      if (!dispOn || !mValid) code = 0;
      else if (mLm) code = lit ? 1 : 3;
      else code = lit ? 0 : 4;
      v[s*3 +: 3] = 3'(code);
    end
    return v;
  endfunction

  function automatic logic [NCOM*3-1:0] expCom();
    logic [NCOM*3-1:0] v;
    for (int c = 0; c < NCOM; c++) begin
      bit sel;
      int code;
      sel = mValid && (mIcon ? (c == NCOM - 1) : (c == mSel));
      if (!dispOn || !mValid) code = 0;
      else if (mLm) code = sel ? 0 : 2;
      else code = sel ? 1 : 5;
      v[c*3 +: 3] = 3'(code);
    end
    return v;
  endfunction

  // per-cycle comparison, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int ea;
      logic [NSEG*3-1:0] es;
      logic [NCOM*3-1:0] ec;
      ea = (mScan >= effDuty(int'(dutyIn))) ? NROW : mLine;
      es = expSeg();
      ec = expCom();
      checks += 3;
      if (int'(ramAddr) != ea) begin
        errors++;
        $display("FAIL R2 R3 R4 ramAddr actual=%0d expected=%0d t=%0t", ramAddr, ea, $time);
      end
      if (segLevel !== es) begin
        errors++;
        $display("FAIL R6 R7 R8 R9 R10 R11 segLevel actual=%h expected=%h t=%0t", segLevel, es, $time);
      end
      if (comLevel !== ec) begin
        errors++;
        $display("FAIL R5 R9 comLevel actual=%h expected=%h t=%0t", comLevel, ec, $time);
      end
    end
  end

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) lineTick = 1'b1;
      @(negedge clk) lineTick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic setStart(int v);
    @(negedge clk) begin startLineWe = 1'b1; startLineIn = 7'(v); end
    @(negedge clk) startLineWe = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (ramAddr !== 7'd0 || segLevel !== '0 || comLevel !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual addr=%0d seg=%h expected addr=0 all VSS", ramAddr, segLevel);
    end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk) dispOn = 1'b1;
    repeat (2) @(negedge clk);
    // R1: still VSS until first strobe
    #1;
    checks++;
    if (segLevel !== '0 || comLevel !== '0) begin
      errors++;
      $display("FAIL R1 pre-strobe outputs actual seg=%h expected 0", segLevel);
    end
    // R3 R4 R5 R6: plain scan, duty 8
    ticks(30, 1);
    // R7 reverse
    reverseOn = 1'b1; ticks(10, 0);
    // R8 allOn beats reverse
    allOn = 1'b1; ticks(10, 0);
    reverseOn = 1'b0; allOn = 1'b0;
    // R10 mirror
    mirrorOn = 1'b1; ticks(12, 1);
    // R9 display off, also with allOn
    dispOn = 1'b0; ticks(5, 0);
    allOn = 1'b1; ticks(3, 0);
    // R11 modes cleared: levels return without a strobe
    @(negedge clk) begin dispOn = 1'b1; allOn = 1'b0; mirrorOn = 1'b0; end
    repeat (3) @(negedge clk);
    // R2 start written mid-frame, wrap past 79
    ticks(3, 0);
    setStart(76);
    dutyIn = 7'd10;
    ticks(40, 0);
    // R2 out-of-range start loads as 0
    setStart(100);
    ticks(25, 0);
    // R3 duty clamps
    setStart(5);
    dutyIn = 7'd0; ticks(6, 0);
    dutyIn = 7'd100; ticks(170, 0);
    // duty lowered mid-frame
    dutyIn = 7'd40; ticks(20, 0);
    dutyIn = 7'd5; ticks(12, 0);
    reverseOn = 1'b1; mirrorOn = 1'b1; ticks(14, 0);
    repeat (4) @(negedge clk);
    #2;
    finishRun();
  end
endmodule